// File: doc/BRIEF.md
# Character Display Controller Core

This block models the controller that sits inside a two-line character display module. A host talks to it through a narrow parallel port. One select line picks between the instruction path and the data path. A direction line picks write or read. A one-cycle request strobe marks each access. The core holds the display text memory, the user pattern memory and a single address counter that both memories share. It also holds the entry-mode, display-control and shift-offset state, and a busy timer that spaces out accepted commands.

The core decodes the command byte by its most significant set bit. It walks the address counter across a split two-line address map that wraps from line to line, and it tracks the display shift as an offset kept apart from the address counter. A renderer downstream reads `ac_o`, `shift_o` and the display-control flags. It fetches the glyph codes from the same memories. Pixel generation, the font table and the narrow 4-bit transfer mode are handled elsewhere.

`LONG_CYC` must be at least `2*LINE_LEN`, because the clear command sweeps the text memory one location per cycle while the core is busy.

Top module: `chardisp_core`

## Requirements
- R1: After reset the core shows `ac_o`=0, `busy_o`=0, `shift_o`=0, all three display flags at 0, `rd_valid_o`=0 and `rdata_o`=0. Entry direction starts as increment and entry shift starts off. The text memory is selected.
- R2: An instruction write (`rs_i`=0, `rw_i`=0) is decoded from the highest set bit of `wdata_i`:
  - bit 7: set text address to bits 6..0
  - bit 6: set pattern address to bits 5..0
  - bit 5: function set, which only starts the short busy time
  - bit 4: cursor/display shift (bit 3 = display-not-cursor, bit 2 = right)
  - bit 3: display control (bit 2 display, bit 1 cursor, bit 0 blink)
  - bit 2: entry mode (bit 1 increment, bit 0 shift)
  - bit 1: home
  - bit 0: clear
  - All bits below the leading one that a command does not name are ignored.
- R3: Clear writes 0x20 to all `2*LINE_LEN` text locations. It sets the address to 0, selects the text memory, resets the shift offset to 0 and forces increment mode. The entry shift flag keeps its value.
- R4: Home sets the address to 0, selects the text memory and resets the shift offset to 0. It leaves both memories unchanged.
- R5: A data write (`rs_i`=1, `rw_i`=0) stores `wdata_i` at the address counter in the selected memory. A data read (`rs_i`=1, `rw_i`=1) returns the stored byte. After either access the counter steps by one: up in increment mode, down otherwise. Read results appear on `rdata_o` with `rd_valid_o`=1 for one cycle, two rising edges after the edge that accepts the read.
- R6: A text-memory write with the entry shift flag set also moves `shift_o`. It adds 1 (modulo `LINE_LEN`) in increment mode and subtracts 1 in decrement mode. Reads and pattern-memory accesses never change `shift_o`.
- R7: The cursor/display shift command behaves as follows.
  - Display-not-cursor = 0: the address steps down when right = 0 and up when right = 1.
  - Display-not-cursor = 1: `shift_o` adds 1 when right = 0 and subtracts 1 when right = 1, modulo `LINE_LEN`. The address is unchanged.
- R8: Text addresses run 0x00..`LINE_LEN`-1 for line one and 0x40..0x40+`LINE_LEN`-1 for line two.
  - Stepping up goes from the end of line one to 0x40, and from the end of line two to 0x00.
  - Stepping down goes from 0x00 to the end of line two, and from 0x40 to the end of line one.
  - Pattern addresses are 6 bits and wrap modulo 64.
  - Text accesses at a column of `LINE_LEN` or above write nothing and read 0x20.
- R9: A status read (`rs_i`=0, `rw_i`=1) returns the busy flag in bit 7 and the address counter in bits 6..0. Both values are taken before the edge that accepts the read. A status read is accepted even while busy and does not start the busy timer.
- R10: Clear and home hold `busy_o` high for `LONG_CYC` cycles. Every other accepted instruction write or data access holds it high for `SHORT_CYC` cycles. While `busy_o` is high, instruction writes and data accesses are ignored.
- R11: Display control sets `disp_on_o`, `cursor_on_o` and `blink_on_o` from bits 2, 1 and 0 of the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle access strobe |
| rs_i | input | 1 | 0 = instruction/status, 1 = data |
| rw_i | input | 1 | 0 = write, 1 = read |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read result, held until the next result |
| rd_valid_o | output | 1 | Marks the cycle a new read result appears |
| busy_o | output | 1 | Busy flag |
| ac_o | output | 7 | Address counter (cursor position) |
| shift_o | output | $clog2(LINE_LEN) | Display shift offset |
| disp_on_o | output | 1 | Display enable |
| cursor_on_o | output | 1 | Cursor visible |
| blink_on_o | output | 1 | Blink enable |

## Verification
The bench keeps the default line length of 40 so that the real wrap points 0x27→0x40 and 0x67→0x00 are exercised, along with a shift offset that wraps from 0 to 39. It shrinks `LONG_CYC` to 100 and `SHORT_CYC` to 3. That keeps every clear and home short while still leaving more than the 80 cycles the clear sweep needs. It also makes back-to-back accesses land inside the short busy window, so the ignore rule can be checked.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  localparam int ADDR_W = 7;
  localparam logic [7:0] BLANK_CODE = 8'h20;

  typedef enum logic [3:0] {
    OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DCTL,
    OP_SHIFT, OP_FUNC, OP_SETCG, OP_SETDD
  } op_e;

  // Leading-one decode of an instruction byte.
  function automatic op_e decode_op(input logic [7:0] b);
    op_e r;
    r = OP_NONE;
    if (b[7])      r = OP_SETDD;
    else if (b[6]) r = OP_SETCG;
    else if (b[5]) r = OP_FUNC;
    else if (b[4]) r = OP_SHIFT;
    else if (b[3]) r = OP_DCTL;
    else if (b[2]) r = OP_ENTRY;
    else if (b[1]) r = OP_HOME;
    else if (b[0]) r = OP_CLEAR;
    return r;
  endfunction

endpackage

// File: rtl/chardisp_ac_step.sv
module chardisp_ac_step #(
  parameter int LINE_LEN = 40
) (
  input  logic [6:0] ac_i,
  input  logic       up_i,
  input  logic       cg_i,
  output logic [6:0] ac_o
);
  localparam logic [6:0] L1_LAST = 7'(LINE_LEN - 1);
  localparam logic [6:0] L2_BASE = 7'h40;
  localparam logic [6:0] L2_LAST = 7'(64 + LINE_LEN - 1);

  always_comb begin
    if (cg_i) begin
      ac_o = {1'b0, (up_i ? ac_i[5:0] + 6'd1 : ac_i[5:0] - 6'd1)};
    end else if (up_i) begin
      if (ac_i == L1_LAST)      ac_o = L2_BASE;
      else if (ac_i == L2_LAST) ac_o = 7'h00;
      else                      ac_o = ac_i + 7'd1;
    end else begin
      if (ac_i == 7'h00)        ac_o = L2_LAST;
      else if (ac_i == L2_BASE) ac_o = L1_LAST;
      else                      ac_o = ac_i - 7'd1;
    end
  end
endmodule

// File: rtl/chardisp_busy.sv
module chardisp_busy #(
  parameter int LONG_CYC  = 205000,
  parameter int SHORT_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;

  // R10: an accepted operation raises the flag on the next cycle
  p_busy_set_r10: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_q);
  // R10: flag drops once the count is spent
  p_busy_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == '0 && !start_i) |=> !busy_q);
endmodule

// File: rtl/chardisp_ram.sv
module chardisp_ram #(
  parameter int DEPTH = 80,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/chardisp_core.sv
module chardisp_core
  import chardisp_pkg::*;
#(
  parameter int LINE_LEN  = 40,
  parameter int LONG_CYC  = 205000,
  parameter int SHORT_CYC = 5000,
  localparam int SH_W     = $clog2(LINE_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic            rs_i,
  input  logic            rw_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic            rd_valid_o,
  output logic            busy_o,
  output logic [6:0]      ac_o,
  output logic [SH_W-1:0] shift_o,
  output logic            disp_on_o,
  output logic            cursor_on_o,
  output logic            blink_on_o
);
  localparam int DD_DEPTH = 2 * LINE_LEN;
  localparam int DD_AW    = $clog2(DD_DEPTH);
  localparam int CG_DEPTH = 64;
  localparam logic [SH_W-1:0] SH_LAST = SH_W'(LINE_LEN - 1);

  typedef enum logic [1:0] {RK_STAT, RK_DD, RK_CG} rkind_e;

  // architectural state
  logic [6:0]      ac_q;
  logic            sel_cg_q, id_q, s_q;
  logic [SH_W-1:0] shift_q;
  logic            clr_run_q;
  logic [DD_AW-1:0] clr_idx_q;
  logic            rd_pend_q, dd_ok_q;
  rkind_e          rkind_q;
  logic [7:0]      stat_q;

  // access qualification
  op_e  op;
  logic acc_status, acc_instr, acc_data, acc_wr;
  assign op         = decode_op(wdata_i);
  assign acc_status = req_i & ~rs_i & rw_i;
  assign acc_instr  = req_i & ~rs_i & ~rw_i & ~busy_o;
  assign acc_data   = req_i & rs_i & ~busy_o;
  assign acc_wr     = acc_data & ~rw_i;

  // text memory index from the two-line address
  logic [5:0]       dd_col;
  logic             dd_ok;
  logic [DD_AW-1:0] dd_idx;
  assign dd_col = ac_q[5:0];
  assign dd_ok  = ({1'b0, dd_col} < 7'(LINE_LEN));
  assign dd_idx = DD_AW'({1'b0, dd_col} + (ac_q[6] ? 7'(LINE_LEN) : 7'd0));

  // address step
  logic [6:0] ac_nxt;
  chardisp_ac_step #(.LINE_LEN(LINE_LEN)) u_step (
    .ac_i (ac_q),
    .up_i (rs_i ? id_q : wdata_i[2]),
    .cg_i (sel_cg_q),
    .ac_o (ac_nxt)
  );

  // shift offset neighbours
  logic [SH_W-1:0] sh_left, sh_right;
  assign sh_left  = (shift_q == SH_LAST) ? '0 : shift_q + 1'b1;
  assign sh_right = (shift_q == '0) ? SH_LAST : shift_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q      <= '0;
      sel_cg_q  <= 1'b0;
      id_q      <= 1'b1;
      s_q       <= 1'b0;
      shift_q   <= '0;
      disp_on_o <= 1'b0;
      cursor_on_o <= 1'b0;
      blink_on_o  <= 1'b0;
      clr_run_q <= 1'b0;
      clr_idx_q <= '0;
    end else begin
      if (clr_run_q) begin
        clr_idx_q <= clr_idx_q + 1'b1;
        if (clr_idx_q == DD_AW'(DD_DEPTH - 1)) clr_run_q <= 1'b0;
      end
      if (acc_instr) begin
        unique case (op)
          OP_CLEAR: begin
            ac_q <= '0; sel_cg_q <= 1'b0; shift_q <= '0; id_q <= 1'b1;
            clr_run_q <= 1'b1; clr_idx_q <= '0;
          end
          OP_HOME:  begin ac_q <= '0; sel_cg_q <= 1'b0; shift_q <= '0; end
          OP_ENTRY: begin id_q <= wdata_i[1]; s_q <= wdata_i[0]; end
          OP_DCTL:  begin
            disp_on_o <= wdata_i[2]; cursor_on_o <= wdata_i[1]; blink_on_o <= wdata_i[0];
          end
          OP_SHIFT: begin
            if (wdata_i[3]) shift_q <= wdata_i[2] ? sh_right : sh_left;
            else            ac_q    <= ac_nxt;
          end
          OP_SETCG: begin ac_q <= {1'b0, wdata_i[5:0]}; sel_cg_q <= 1'b1; end
          OP_SETDD: begin ac_q <= wdata_i[6:0]; sel_cg_q <= 1'b0; end
          default: ;
        endcase
      end
      if (acc_data) begin
        ac_q <= ac_nxt;
        if (!rw_i && !sel_cg_q && s_q) shift_q <= id_q ? sh_left : sh_right;
      end
    end
  end

  // memories
  logic [7:0] dd_rd, cg_rd;
  chardisp_ram #(.DEPTH(DD_DEPTH), .DW(8)) u_dd (
    .clk     (clk),
    .we_i    (clr_run_q | (acc_wr & ~sel_cg_q & dd_ok)),
    .addr_i  (clr_run_q ? clr_idx_q : dd_idx),
    .wdata_i (clr_run_q ? BLANK_CODE : wdata_i),
    .rdata_o (dd_rd)
  );
  chardisp_ram #(.DEPTH(CG_DEPTH), .DW(8)) u_cg (
    .clk     (clk),
    .we_i    (acc_wr & sel_cg_q),
    .addr_i  (ac_q[5:0]),
    .wdata_i (wdata_i),
    .rdata_o (cg_rd)
  );

  // read return pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q  <= 1'b0;
      rkind_q    <= RK_STAT;
      stat_q     <= '0;
      dd_ok_q    <= 1'b0;
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_pend_q  <= acc_status | (acc_data & rw_i);
      rkind_q    <= acc_status ? RK_STAT : (sel_cg_q ? RK_CG : RK_DD);
      stat_q     <= {busy_o, ac_q};
      dd_ok_q    <= dd_ok;
      rd_valid_o <= rd_pend_q;
      if (rd_pend_q) begin
        unique case (rkind_q)
          RK_STAT: rdata_o <= stat_q;
          RK_CG:   rdata_o <= cg_rd;
          default: rdata_o <= dd_ok_q ? dd_rd : BLANK_CODE;
        endcase
      end
    end
  end

  chardisp_busy #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_busy (
    .clk     (clk),
    .rst     (rst),
    .start_i (acc_instr | acc_data),
    .long_i  (~rs_i & (op == OP_CLEAR || op == OP_HOME)),
    .busy_o  (busy_o)
  );

  assign ac_o    = ac_q;
  assign shift_o = shift_q;

  // R10: nothing moves the counter or the offset while busy
  p_ac_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(ac_q));
  p_shift_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(shift_q));
  // R8: line one end continues on line two
  p_line_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (acc_data && !sel_cg_q && id_q && ac_q == 7'(LINE_LEN - 1)) |=> ac_q == 7'h40);
  // R3: clear leaves origin, no shift, increment mode
  p_clear_state_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_instr && wdata_i == 8'h01) |=> (ac_q == 7'h00 && shift_q == '0 && id_q));
  // R6: pattern memory traffic never moves the display
  p_cg_no_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_data && sel_cg_q) |=> $stable(shift_q));
  // R9: status result carries the pre-access counter
  p_status_r9: assert property (@(posedge clk) disable iff (rst)
    acc_status |=> ##1 (rd_valid_o && rdata_o[6:0] == $past(ac_q, 2)));
endmodule

// File: tb/chardisp_core_tb.sv
module chardisp_core_tb;
  localparam int LINE_LEN = 40;
  localparam int LONG_CYC = 100;
  localparam int SHORT_CYC = 3;
  localparam int SH_W = $clog2(LINE_LEN);

  logic clk = 0, rst = 1;
  logic req = 0, rs = 0, rw = 0;
  logic [7:0] wd = 0;
  logic [7:0] rdata;
  logic rd_valid, busy, d_on, c_on, b_on;
  logic [6:0] ac;
  logic [SH_W-1:0] shift;

  always #4 clk = ~clk;

  chardisp_core #(.LINE_LEN(LINE_LEN), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .rs_i(rs), .rw_i(rw), .wdata_i(wd),
    .rdata_o(rdata), .rd_valid_o(rd_valid), .busy_o(busy), .ac_o(ac), .shift_o(shift),
    .disp_on_o(d_on), .cursor_on_o(c_on), .blink_on_o(b_on)
  );

  int checks = 0, failures = 0, cycles = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ac, m_cg, m_id, m_s, m_d, m_c, m_b, m_ofs, m_rem, m_rv, m_rd, p_v, p_d;
  int dd_m[2*LINE_LEN];
  int cg_m[64];

  function automatic int m_step(input int a, input int up, input int cg);
    if (cg != 0) return up != 0 ? (a + 1) % 64 : (a + 63) % 64;
    if (up != 0) begin
      if (a == LINE_LEN - 1) return 64;
      if (a == 64 + LINE_LEN - 1) return 0;
      return a + 1;
    end
    if (a == 0) return 64 + LINE_LEN - 1;
    if (a == 64) return LINE_LEN - 1;
    return a - 1;
  endfunction

  function automatic int m_idx(input int a);
    int col = a % 64;
    if (col >= LINE_LEN) return -1;
    return (a >= 64 ? LINE_LEN : 0) + col;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ac = 0; m_cg = 0; m_id = 1; m_s = 0; m_d = 0; m_c = 0; m_b = 0;
      m_ofs = 0; m_rem = 0; m_rv = 0; m_rd = 0; p_v = 0; p_d = 0;
    end else begin
      int bsy, top, ix;
      bsy = (m_rem > 0);
      m_rv = p_v;
      if (p_v != 0) m_rd = p_d;
      p_v = 0;
      if (m_rem > 0) m_rem--;
      if (req) begin
        if (!rs && rw) begin
          p_v = 1; p_d = bsy * 128 + m_ac;
        end else if (bsy == 0 && !rs) begin
          top = -1;
          for (int k = 7; k >= 0; k--) if (top < 0 && wd[k]) top = k;
          m_rem = (top == 0 || top == 1) ? LONG_CYC : SHORT_CYC;
          case (top)
            0: begin
              foreach (dd_m[i]) dd_m[i] = 32;
              m_ac = 0; m_cg = 0; m_ofs = 0; m_id = 1;
            end
            1: begin m_ac = 0; m_cg = 0; m_ofs = 0; end
            2: begin m_id = wd[1]; m_s = wd[0]; end
            3: begin m_d = wd[2]; m_c = wd[1]; m_b = wd[0]; end
            4: begin
              if (wd[3]) m_ofs = wd[2] ? (m_ofs + LINE_LEN - 1) % LINE_LEN : (m_ofs + 1) % LINE_LEN;
              else m_ac = m_step(m_ac, wd[2], m_cg);
            end
            6: begin m_ac = wd[5:0]; m_cg = 1; end
            7: begin m_ac = wd[6:0]; m_cg = 0; end
            default: ;
          endcase
        end else if (bsy == 0 && rs) begin
          m_rem = SHORT_CYC;
          ix = m_idx(m_ac);
          if (rw) begin
            p_v = 1;
            if (m_cg != 0) p_d = cg_m[m_ac % 64];
            else p_d = (ix < 0) ? 32 : dd_m[ix];
          end else begin
            if (m_cg != 0) cg_m[m_ac % 64] = wd;
            else begin
              if (ix >= 0) dd_m[ix] = wd;
              if (m_s != 0) m_ofs = m_id != 0 ? (m_ofs + 1) % LINE_LEN : (m_ofs + LINE_LEN - 1) % LINE_LEN;
            end
          end
          m_ac = m_step(m_ac, m_id, m_cg);
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5/R8 ac_o", ac, m_ac);
      chk("R10 busy_o", busy, m_rem > 0);
      chk("R6/R7 shift_o", shift, m_ofs);
      chk("R11 flags", {d_on, c_on, b_on}, m_d * 4 + m_c * 2 + m_b);
      chk("R5/R9 rd_valid_o", rd_valid, m_rv);
      if (m_rv != 0) chk("R5/R9 rdata_o", rdata, m_rd);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      failures++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input logic r_s, input logic r_w, input logic [7:0] d);
    @(negedge clk); req = 1; rs = r_s; rw = r_w; wd = d;
    @(negedge clk); req = 0;
  endtask
  task automatic idle();
    while (busy) @(negedge clk);
  endtask
  task automatic cmd(input logic [7:0] d); acc(0, 0, d); idle(); endtask
  task automatic wr(input logic [7:0] d); acc(1, 0, d); idle(); endtask
  task automatic rd(output logic [7:0] v);
    acc(1, 1, 8'h00); @(negedge clk); v = rdata; idle();
  endtask
  task automatic stat(output logic [7:0] v);
    acc(0, 1, 8'h00); @(negedge clk); v = rdata;
  endtask

  initial begin
    logic [7:0] v;
    int a0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ac", ac, 0); chk("R1 busy", busy, 0); chk("R1 shift", shift, 0);
    chk("R1 flags", {d_on, c_on, b_on}, 0); chk("R1 rd_valid", rd_valid, 0);
    stat(v); chk("R9 idle status", v, 8'h00);

    // R3 clear, R9/R10 busy status and ignore
    acc(0, 0, 8'h01);
    stat(v); chk("R9 busy bit during clear", v[7], 1);
    acc(0, 0, 8'h0F);
    chk("R10 ignored while busy", d_on, 0);
    idle();
    chk("R10 still off after busy", d_on, 0);
    cmd(8'h0F); chk("R11 all flags on", {d_on, c_on, b_on}, 7);
    cmd(8'h0A); chk("R11 cursor only", {d_on, c_on, b_on}, 2);
    cmd(8'h0C);
    cmd(8'h80); rd(v); chk("R3 blank after clear", v, 8'h20);

    // R5 R8 forward writes across the line boundary
    cmd(8'h06); cmd(8'hA5);
    wr("A"); wr("B"); wr("C"); wr("D");
    chk("R8 wrap into line two", ac, 7'h41);
    cmd(8'hA5);
    rd(v); chk("R5 read A", v, "A"); rd(v); chk("R5 read B", v, "B");
    rd(v); chk("R5 read C", v, "C"); rd(v); chk("R5 read D", v, "D");

    // R8 reverse wraps
    cmd(8'h04); cmd(8'hC0); wr("x"); chk("R8 0x40 down", ac, 7'h27);
    cmd(8'h80); wr("y"); chk("R8 0x00 down", ac, 7'h67);
    cmd(8'h06); wr("z"); chk("R8 0x67 up", ac, 7'h00);
    cmd(8'hE7); rd(v); chk("R8 last cell", v, "z");

    // R10 data access inside busy window is dropped
    a0 = ac;
    acc(1, 0, "Q"); acc(1, 0, "R"); idle();
    chk("R10 second write dropped", ac, a0 + 1);

    // R6 entry shift
    cmd(8'h07); wr("s"); chk("R6 left on write", shift, 1);
    cmd(8'h05); wr("t"); chk("R6 right on write", shift, 0);
    wr("u"); chk("R6 wrap to last", shift, LINE_LEN - 1);
    rd(v); chk("R6 read no shift", shift, LINE_LEN - 1);

    // R7 cursor / display shift
    a0 = ac;
    cmd(8'h18); chk("R7 display left", shift, 0); chk("R7 ac kept", ac, a0);
    cmd(8'h1C); chk("R7 display right", shift, LINE_LEN - 1);
    cmd(8'hC5);
    cmd(8'h10); chk("R7 cursor left", ac, 7'h44);
    cmd(8'h14); chk("R7 cursor right", ac, 7'h45);

    // R4 home
    cmd(8'h02); chk("R4 ac", ac, 0); chk("R4 shift", shift, 0);
    cmd(8'hA5); rd(v); chk("R4 contents kept", v, "A");

    // R8 R6 pattern memory wrap, no display movement
    cmd(8'h07); cmd(8'h7E);
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk("R8 pattern wrap", ac, 7'h01); chk("R6 pattern no shift", shift, 0);
    cmd(8'h7E);
    rd(v); chk("R5 pattern 0", v, 8'h11); rd(v); chk("R5 pattern 1", v, 8'h22);
    rd(v); chk("R5 pattern 2", v, 8'h33);

    // R2 function set and leading-one decode
    acc(0, 0, 8'h38); chk("R2 function set busy", busy, 1); idle();
    chk("R2 function set no ac change", ac, 7'h01);
    cmd(8'h1F); chk("R2 bit4 leads", shift, LINE_LEN - 1);
    cmd(8'h03); chk("R2 bit1 leads home ac", ac, 0); chk("R2 bit1 leads home shift", shift, 0);

    // R3 clear forces increment, keeps S
    cmd(8'h05); cmd(8'hA5);
    cmd(8'h01);
    wr("k"); chk("R3 increment forced", ac, 1); chk("R3 S kept", shift, 1);
    cmd(8'hA5); rd(v); chk("R3 cell blanked", v, 8'h20);
    cmd(8'hE7); rd(v); chk("R3 last cell blanked", v, 8'h20);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule